// File: doc/BRIEF.md
# Double-Buffered Serial Shift Slice

This block is one channel of a software-driven serial pin engine. It turns a parallel word into a timed bit stream on a single pin, or captures a bit stream from the pin into a word. Two 32-bit registers carry the data. The active register does the shifting. The shadow register is the one software sees. When a word completes, the two registers trade their contents in one cycle. Software therefore has a whole word period to refill the shadow register (output direction) or to read it (input direction), and the stream has no gap.

The timing comes from two cascaded down-counters. A 12-bit rate counter runs on every clock and produces one shift event each time it expires. An 8-bit length counter counts those shift events and marks the end of a word. Both counters reload from presets that software writes through a small register port. A one-cycle strobe tells software when an exchange has taken place.

Top module: `dbuf_shift_slice`

## Requirements
- R1: After reset the shadow register, both presets and the active register are zero, `pin_out` is 0 and `swap_stb` is 0.
- R2: The register port decodes address 0 as the 32-bit shadow register, address 1 as the 12-bit rate preset (bits 11:0), and address 2 as the 8-bit length preset (bits 7:0). Address 3 reads as zero. Writes take effect at the clock edge. `rd_data` follows `rd_addr` combinationally, with the unused upper bits read as zero.
- R3: While enabled with rate preset C, a shift event occurs once every C+1 clocks. The first event comes C+1 clocks after the slice is enabled.
- R4: With length preset P, the exchange happens on the P-th shift event of each word. A preset of 0 behaves like 1.
- R5: At the exchange, the active register takes the old shadow value. In the same edge, the shadow register takes the active value as updated by that final shift.
- R6: In output mode (`dir_out`=1), `pin_out` shows bit 0 of the active register. Each shift moves the register right and fills bit 31 with 0. `pin_oe` equals `dir_out`.
- R7: In input mode (`dir_out`=0), each shift moves the active register right and loads `pin_in` into bit 31. The first bit received of a 8-bit word ends in bit 24.
- R8: `swap_stb` is high for the clock that follows each exchange edge, and only then.
- R9: While `en` is 0, no shift or exchange occurs, both counters hold their presets, and `pin_out` keeps its value.
- R10: A shadow write in the same cycle as an exchange is dropped, and the shadow register keeps the exchanged value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Slice enable |
| dir_out | input | 1 | 1 = shift out to pin, 0 = capture from pin |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Register read data |
| pin_in | input | 1 | Serial pin input |
| pin_out | output | 1 | Serial pin output value |
| pin_oe | output | 1 | Serial pin output enable |
| swap_stb | output | 1 | One-cycle exchange indication |

## Verification
Some properties are checked on every cycle. Both counters reload their presets on expiry and otherwise count down by one. A word end only ever coincides with a shift event. The exchange brings the old shadow value into the active register. The active register is zero-filled at the top in output mode and loads the pin value at the top in input mode. A disabled slice produces no strobe and keeps its pin steady. The bench scenarios show the properties that depend on the whole sequence: the exact clock on which each bit appears, the word length from the length preset, the value left in the shadow after a word, the dropped write that collides with an exchange, and the register port decode.

// File: rtl/dbuf_slice_pkg.sv
package dbuf_slice_pkg;

    // Register port address map; the bench and software depend on these codes
    typedef enum logic [1:0] {
        REG_SHADOW = 2'd0,
        REG_RATE   = 2'd1,
        REG_LEN    = 2'd2,
        REG_NONE   = 2'd3
    } slice_reg_e;

endpackage

// File: rtl/slice_rate_ctr.sv
module slice_rate_ctr #(
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] preset,
    output logic             tick
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } rate_st_t;

    rate_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = 1'b0;
        if (!en) begin
            st_d.cnt = preset;
        end else if (st_q.cnt == '0) begin
            tick     = 1'b1;
            st_d.cnt = preset;
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: expiry reloads the preset
    a_r3_reload : assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (st_q.cnt == $past(preset)));

    // R3: between expiries the counter steps down by one
    a_r3_step : assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tick) |=> (st_q.cnt == $past(st_q.cnt) - 1'b1));

    // R9: idle counter sits at its preset
    a_r9_rate_idle : assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (st_q.cnt == $past(preset)));

endmodule

// File: rtl/slice_len_ctr.sv
module slice_len_ctr #(
    parameter int unsigned POS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic [POS_W-1:0] preset,
    output logic             word_end
);

    typedef struct packed {
        logic [POS_W-1:0] pos;
    } len_st_t;

    len_st_t st_d, st_q;
    logic    last_bit;

    // A count of 0 or 1 means the coming shift finishes the word
    assign last_bit = (st_q.pos == '0) || (st_q.pos == POS_W'(1));

    always_comb begin
        st_d     = st_q;
        word_end = 1'b0;
        if (!en) begin
            st_d.pos = preset;
        end else if (tick) begin
            if (last_bit) begin
                word_end = 1'b1;
                st_d.pos = preset;
            end else begin
                st_d.pos = st_q.pos - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4: a word can only end on a shift event
    a_r4_end_on_tick : assert property (@(posedge clk) disable iff (!rst_n)
        word_end |-> tick);

    // R4: position holds between shift events while running
    a_r4_hold : assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tick) |=> $stable(st_q.pos));

endmodule

// File: rtl/slice_cfg_regs.sv
module slice_cfg_regs #(
    parameter int unsigned CNT_W = 12,
    parameter int unsigned POS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_rate,
    input  logic             wr_len,
    input  logic [CNT_W-1:0] wr_rate_val,
    input  logic [POS_W-1:0] wr_len_val,
    output logic [CNT_W-1:0] rate_preset,
    output logic [POS_W-1:0] len_preset
);

    typedef struct packed {
        logic [CNT_W-1:0] rate;
        logic [POS_W-1:0] len;
    } cfg_st_t;

    cfg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_rate) st_d.rate = wr_rate_val;
        if (wr_len)  st_d.len  = wr_len_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rate_preset = st_q.rate;
    assign len_preset  = st_q.len;

    // R2: a write is visible after its edge
    a_r2_rate_wr : assert property (@(posedge clk) disable iff (!rst_n)
        wr_rate |=> (rate_preset == $past(wr_rate_val)));

endmodule

// File: rtl/slice_shift_data.sv
module slice_shift_data #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              dir_out,
    input  logic              tick,
    input  logic              word_end,
    input  logic              wr_shadow,
    input  logic [DATA_W-1:0] wr_val,
    input  logic              pin_in,
    output logic [DATA_W-1:0] shadow,
    output logic              pin_out,
    output logic              swap_stb
);

    typedef struct packed {
        logic [DATA_W-1:0] active;
        logic [DATA_W-1:0] shadow;
        logic              pin;
        logic              stb;
    } data_st_t;

    data_st_t          st_d, st_q;
    logic [DATA_W-1:0] shifted;
    logic              fill_bit;

    // Output mode empties from the top, input mode captures at the top
    assign fill_bit = dir_out ? 1'b0 : pin_in;
    assign shifted  = {fill_bit, st_q.active[DATA_W-1:1]};

    always_comb begin
        st_d     = st_q;
        st_d.stb = 1'b0;
        if (wr_shadow) st_d.shadow = wr_val;
        if (tick)      st_d.active = shifted;
        if (word_end) begin
            // exchange wins over a same-cycle software write
            st_d.active = st_q.shadow;
            st_d.shadow = shifted;
            st_d.stb    = 1'b1;
        end
        if (en && dir_out) st_d.pin = st_d.active[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign shadow   = st_q.shadow;
    assign pin_out  = st_q.pin;
    assign swap_stb = st_q.stb;

    // R5: exchange brings the old shadow into the active register
    a_r5_swap_in : assert property (@(posedge clk) disable iff (!rst_n)
        word_end |=> (st_q.active == $past(st_q.shadow)));

    // R6: output shifting fills the top bit with zero
    a_r6_zero_fill : assert property (@(posedge clk) disable iff (!rst_n)
        (tick && dir_out && !word_end) |=> (st_q.active[DATA_W-1] == 1'b0));

    // R7: input shifting captures the pin at the top bit
    a_r7_capture : assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !dir_out && !word_end) |=> (st_q.active[DATA_W-1] == $past(pin_in)));

    // R10: a write without exchange lands in the shadow register
    a_r10_plain_wr : assert property (@(posedge clk) disable iff (!rst_n)
        (wr_shadow && !word_end) |=> (st_q.shadow == $past(wr_val)));

endmodule

// File: rtl/dbuf_shift_slice.sv
module dbuf_shift_slice
    import dbuf_slice_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 12,
    parameter int unsigned POS_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              dir_out,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              pin_in,
    output logic              pin_out,
    output logic              pin_oe,
    output logic              swap_stb
);

    logic              wr_shadow, wr_rate, wr_len;
    logic [CNT_W-1:0]  rate_preset;
    logic [POS_W-1:0]  len_preset;
    logic              tick, word_end;
    logic [DATA_W-1:0] shadow;

    assign wr_shadow = wr_en && (slice_reg_e'(wr_addr) == REG_SHADOW);
    assign wr_rate   = wr_en && (slice_reg_e'(wr_addr) == REG_RATE);
    assign wr_len    = wr_en && (slice_reg_e'(wr_addr) == REG_LEN);

    slice_cfg_regs #(.CNT_W(CNT_W), .POS_W(POS_W)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_rate     (wr_rate),
        .wr_len      (wr_len),
        .wr_rate_val (wr_data[CNT_W-1:0]),
        .wr_len_val  (wr_data[POS_W-1:0]),
        .rate_preset (rate_preset),
        .len_preset  (len_preset)
    );

    slice_rate_ctr #(.CNT_W(CNT_W)) u_rate (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .preset (rate_preset),
        .tick   (tick)
    );

    slice_len_ctr #(.POS_W(POS_W)) u_len (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .tick     (tick),
        .preset   (len_preset),
        .word_end (word_end)
    );

    slice_shift_data #(.DATA_W(DATA_W)) u_data (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .dir_out   (dir_out),
        .tick      (tick),
        .word_end  (word_end),
        .wr_shadow (wr_shadow),
        .wr_val    (wr_data),
        .pin_in    (pin_in),
        .shadow    (shadow),
        .pin_out   (pin_out),
        .swap_stb  (swap_stb)
    );

    assign pin_oe = dir_out;

    always_comb begin
        case (slice_reg_e'(rd_addr))
            REG_SHADOW: rd_data = shadow;
            REG_RATE:   rd_data = DATA_W'(rate_preset);
            REG_LEN:    rd_data = DATA_W'(len_preset);
            default:    rd_data = '0;
        endcase
    end

    // R9: no exchange strobe after an idle cycle
    a_r9_idle_no_swap : assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !swap_stb);

    // R9: pin is frozen while idle
    a_r9_pin_hold : assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(pin_out));

    // R8: the strobe follows an exchange edge
    a_r8_stb_after_end : assert property (@(posedge clk) disable iff (!rst_n)
        word_end |=> swap_stb);

endmodule

// File: tb/test_dbuf_shift_slice.sv
module test_dbuf_shift_slice;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        dir_out = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        pin_in = 1'b0;
    logic        pin_out, pin_oe, swap_stb;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    dbuf_shift_slice i_dbuf_shift_slice (
        .clk(clk), .rst_n(rst_n), .en(en), .dir_out(dir_out),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .swap_stb(swap_stb)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; en = 1'b0; dir_out = 1'b0; wr_en = 1'b0; pin_in = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic t_reset_and_regs();
        logic [31:0] v;
        do_reset();
        rd_reg(2'd0, v); chk("R1 shadow", v, 32'h0);
        rd_reg(2'd1, v); chk("R1 rate", v, 32'h0);
        rd_reg(2'd2, v); chk("R1 len", v, 32'h0);
        chk("R1 pin_out", {31'b0, pin_out}, 32'h0);
        chk("R1 swap_stb", {31'b0, swap_stb}, 32'h0);
        wr_reg(2'd0, 32'hCAFE_F00D);
        wr_reg(2'd1, 32'h000A_BCDE);
        wr_reg(2'd2, 32'h0000_1234);
        wr_reg(2'd3, 32'hFFFF_FFFF);
        rd_reg(2'd0, v); chk("R2 shadow", v, 32'hCAFE_F00D);
        rd_reg(2'd1, v); chk("R2 rate 12b", v, 32'h0000_0CDE);
        rd_reg(2'd2, v); chk("R2 len 8b", v, 32'h0000_0034);
        rd_reg(2'd3, v); chk("R2 addr3 zero", v, 32'h0);
    endtask

    // Rate 2 (shift every 3 clocks), length 4, output mode
    task automatic t_output_stream();
        logic [31:0] v;
        do_reset();
        wr_reg(2'd0, 32'h0000_00A5);
        wr_reg(2'd1, 32'd2);
        wr_reg(2'd2, 32'd4);
        step();
        dir_out = 1'b1; en = 1'b1;
        for (int k = 1; k <= 24; k++) begin
            step();
            if (k == 11) chk("R8 no early stb", {31'b0, swap_stb}, 32'h0);
            if (k == 11) chk("R3 dummy word pin", {31'b0, pin_out}, 32'h0);
            if (k == 12) chk("R4 stb at 4th shift", {31'b0, swap_stb}, 32'h1);
            if (k == 13) chk("R8 stb one cycle", {31'b0, swap_stb}, 32'h0);
            if (k == 12) chk("R6 bit0", {31'b0, pin_out}, 32'h1);
            if (k == 14) chk("R3 no shift before C+1", {31'b0, pin_out}, 32'h1);
            if (k == 15) chk("R6 bit1", {31'b0, pin_out}, 32'h0);
            if (k == 18) chk("R6 bit2", {31'b0, pin_out}, 32'h1);
            if (k == 21) chk("R6 bit3", {31'b0, pin_out}, 32'h0);
            if (k == 24) chk("R4 second word stb", {31'b0, swap_stb}, 32'h1);
        end
        en = 1'b0;
        chk("R6 pin_oe", {31'b0, pin_oe}, 32'h1);
        rd_reg(2'd0, v); chk("R5 shadow holds remainder", v, 32'h0000_000A);
    endtask

    // Rate 0, length 8, input mode, pattern 0xC3 sent LSB first
    task automatic t_input_capture();
        logic [31:0] v;
        logic [7:0]  pat = 8'hC3;
        do_reset();
        wr_reg(2'd0, 32'h5555_5555);
        wr_reg(2'd1, 32'd0);
        wr_reg(2'd2, 32'd8);
        step();
        dir_out = 1'b0; en = 1'b1; pin_in = pat[0];
        for (int k = 1; k <= 8; k++) begin
            step();
            if (k < 8) pin_in = pat[k];
            if (k == 7) chk("R8 no stb mid word", {31'b0, swap_stb}, 32'h0);
        end
        en = 1'b0;
        chk("R8 stb after 8th", {31'b0, swap_stb}, 32'h1);
        chk("R6 pin_oe low in input", {31'b0, pin_oe}, 32'h0);
        rd_reg(2'd0, v); chk("R7 captured word", v, 32'hC300_0000);
    endtask

    // Write colliding with exchange, idle hold, length preset 0
    task automatic t_collision_and_idle();
        logic [31:0] v;
        do_reset();
        wr_reg(2'd0, 32'h1234_5679);
        wr_reg(2'd1, 32'd0);
        wr_reg(2'd2, 32'd2);
        step();
        dir_out = 1'b1; en = 1'b1;
        step();
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = 32'hDEAD_BEEF;
        step();
        wr_en = 1'b0; en = 1'b0;
        chk("R8 stb on exchange", {31'b0, swap_stb}, 32'h1);
        rd_reg(2'd0, v); chk("R10 write dropped", v, 32'h0);
        chk("R5 new active bit0", {31'b0, pin_out}, 32'h1);
        step();
        chk("R9 no stb idle", {31'b0, swap_stb}, 32'h0);
        repeat (4) step();
        chk("R9 pin holds", {31'b0, pin_out}, 32'h1);
        rd_reg(2'd0, v); chk("R9 shadow unchanged idle", v, 32'h0);
        wr_reg(2'd2, 32'd0);
        step();
        en = 1'b1;
        step();
        chk("R4 len0 exchange 1st", {31'b0, swap_stb}, 32'h1);
        chk("R5 active from shadow", {31'b0, pin_out}, 32'h0);
        step();
        chk("R4 len0 exchange 2nd", {31'b0, swap_stb}, 32'h1);
        en = 1'b0;
        rd_reg(2'd0, v); chk("R5 shadow after swap back", v, 32'h0);
    endtask

    initial begin
        #(200000 * 20);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset_and_regs();
        t_output_stream();
        t_input_capture();
        t_collision_and_idle();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule